// File: doc/BRIEF.md
# Receive Frame Length Filter

This block sits beside the receive path of an Ethernet MAC and watches each frame as its bytes are written into one of several receive buffers. It counts the bytes of the frame and applies two size limits that have different policies. The buffer-capacity limit comes from a small size code: a frame longer than the selected capacity is dropped in hardware, and only an overrun flag for the target buffer records it. The maximum-length limit is a byte count that software programs: a frame longer than it is kept, but it raises a babble flag that can request an interrupt, and its buffer stays held until software has released it.

A frame is marked by a start pulse, which also selects the target buffer, by one byte strobe per received byte, and by an end pulse that may come with the last byte. The outcome is latched into the flag bank on the clock edge that samples the end pulse. Software clears flags by writing ones on the clear inputs. A per-buffer free vector tells the buffer allocator which buffers it may reuse.

Top module: `rx_len_filter`

## Requirements
- R1: The buffer capacity is 96 bytes shifted left by the size code. Codes of 4 and above all give 1536 bytes. A frame whose byte count exceeds the capacity sets the overrun flag of its target buffer, and that buffer's valid flag is not set.
- R2: A frame dropped for capacity sets neither a valid flag nor the babble flag, even when it also exceeds the maximum length.
- R3: A frame that fits the capacity but whose byte count exceeds the maximum length sets the valid flag of its buffer and the babble flag. It does not set any overrun flag.
- R4: A frame within both limits sets only its buffer's valid flag. Flags change only on the clock edge that samples an end pulse, or through a clear.
- R5: The interrupt output is high exactly when the babble flag is set and the babble interrupt enable is high.
- R6: Every flag is write-one-to-clear. A clear and a set of the same flag in the same cycle leave the flag set.
- R7: Bit i of the free vector is low while buffer i holds a valid frame, or while buffer i received the frame that set the babble flag and that flag is still set. The bit returns high only when both have been cleared.
- R8: The byte counter is 12 bits wide and saturates at 4095 instead of wrapping. A 4100-byte frame therefore still overruns a 1536-byte buffer.
- R9: Byte strobes and end pulses outside a frame are ignored. A start pulse inside a frame restarts the count from zero and reselects the target buffer.
- R10: A count equal to a limit does not exceed it: 96 bytes fit code 0, and a maximum length of 100 accepts 100 bytes without babble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sofIn | input | 1 | Start-of-frame pulse; samples bufSel |
| bufSel | input | 2 | Target buffer index for the frame |
| byteValid | input | 1 | One received byte written this cycle |
| eofIn | input | 1 | End of frame; may come with the last byte |
| sizeCode | input | 3 | Buffer capacity code |
| maxLen | input | 12 | Maximum frame length in bytes |
| babbleIe | input | 1 | Babble interrupt enable |
| clrValid | input | 3 | Write-one-to-clear for the valid flags |
| clrOverrun | input | 3 | Write-one-to-clear for the overrun flags |
| clrBabble | input | 1 | Write-one-to-clear for the babble flag |
| validFlags | output | 3 | Per-buffer frame-received flags |
| overrunFlags | output | 3 | Per-buffer capacity-overrun flags |
| babbleFlag | output | 1 | Maximum-length exceeded flag |
| irq | output | 1 | Babble interrupt request |
| bufFree | output | 3 | Per-buffer free indication |

## Verification
The frame table pairs byte counts with size codes and length limits so that each frame lands on one side of one limit. Counts of exactly the capacity and one more tell an off-by-one comparison apart from a correct one. Counts that exceed both limits show that the capacity drop takes priority. A code above 4 shows the clamp, and a 4100-byte frame shows whether the counter saturates or wraps. Directed sequences cover a clear in the same cycle as a set, each order of releasing a babbling buffer, the interrupt enable, strobes outside a frame, and a start pulse in the middle of a frame.

// File: rtl/rxlf_pkg.sv
package rxlf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic frameStart;
    logic byteTick;
  } dpStrobe_t;

  // Limit comparison results returned by the datapath (include this cycle's byte)
  typedef struct packed {
    logic overCap;
    logic overMax;
  } dpStatus_t;
endpackage

// File: rtl/rxlf_datapath.sv
module rxlf_datapath
  import rxlf_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int CODE_W   = 3,
  parameter int BASE_CAP = 96,
  parameter int MAX_CODE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CODE_W-1:0] sizeCode,
  input  logic [CNT_W-1:0]  maxLen,
  output dpStatus_t         status
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [CODE_W-1:0] CODE_LIM = CODE_W'(MAX_CODE);
  localparam logic [CNT_W-1:0]  CAP_UNIT = CNT_W'(BASE_CAP);

  logic [CNT_W-1:0]  byteCnt;
  logic [CNT_W-1:0]  cntBase;
  logic [CNT_W-1:0]  cntNext;
  logic [CODE_W-1:0] capCode;
  logic [CNT_W-1:0]  capBytes;

  always_comb begin
    capCode  = (sizeCode > CODE_LIM) ? CODE_LIM : sizeCode;
    capBytes = CAP_UNIT << capCode;
  end

  always_comb begin
    cntBase = strobe.frameStart ? '0 : byteCnt;
    if (strobe.byteTick && cntBase != CNT_MAX) cntNext = cntBase + 1'b1;
    else                                       cntNext = cntBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteCnt <= '0;
    else       byteCnt <= cntNext;
  end

  assign status.overCap = cntNext > capBytes;
  assign status.overMax = cntNext > maxLen;
endmodule

// File: rtl/rxlf_ctrl.sv
module rxlf_ctrl
  import rxlf_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int BUF_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sofIn,
  input  logic [BUF_W-1:0]   bufSel,
  input  logic               byteValid,
  input  logic               eofIn,
  input  dpStatus_t          status,
  output dpStrobe_t          strobe,
  output logic [NUM_BUF-1:0] setValid,
  output logic [NUM_BUF-1:0] setOverrun,
  output logic               setBabble
);
  localparam logic [NUM_BUF-1:0] ONE_HOT0 = NUM_BUF'(1);

  logic             inFrame;
  logic [BUF_W-1:0] bufIdx;
  logic [BUF_W-1:0] curBuf;
  logic             active;
  logic             endNow;
  logic [NUM_BUF-1:0] bufMask;

  assign active = inFrame | sofIn;
  assign curBuf = sofIn ? bufSel : bufIdx;
  assign endNow = eofIn & active;
  assign bufMask = ONE_HOT0 << curBuf;

  assign strobe.frameStart = sofIn;
  assign strobe.byteTick   = byteValid & active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bufIdx  <= '0;
    end else begin
      inFrame <= active & ~eofIn;
      if (sofIn) bufIdx <= bufSel;
    end
  end

  // Capacity overrun wins over the maximum-length check
  always_comb begin
    setValid   = '0;
    setOverrun = '0;
    setBabble  = 1'b0;
    if (endNow) begin
      if (status.overCap) begin
        setOverrun = bufMask;
      end else begin
        setValid  = bufMask;
        setBabble = status.overMax;
      end
    end
  end
endmodule

// File: rtl/rxlf_flags.sv
module rxlf_flags #(
  parameter int NUM_BUF = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] setValid,
  input  logic [NUM_BUF-1:0] setOverrun,
  input  logic               setBabble,
  input  logic [NUM_BUF-1:0] clrValid,
  input  logic [NUM_BUF-1:0] clrOverrun,
  input  logic               clrBabble,
  input  logic               babbleIe,
  output logic [NUM_BUF-1:0] validFlags,
  output logic [NUM_BUF-1:0] overrunFlags,
  output logic               babbleFlag,
  output logic               irq,
  output logic [NUM_BUF-1:0] bufFree
);
  logic [NUM_BUF-1:0] babbleOwner;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validFlags[i]   <= 1'b0;
        overrunFlags[i] <= 1'b0;
        babbleOwner[i]  <= 1'b0;
      end else begin
        validFlags[i]   <= (validFlags[i] & ~clrValid[i]) | setValid[i];
        overrunFlags[i] <= (overrunFlags[i] & ~clrOverrun[i]) | setOverrun[i];
        babbleOwner[i]  <= (babbleOwner[i] & ~clrBabble) | (setBabble & setValid[i]);
      end
    end
    assign bufFree[i] = ~(validFlags[i] | babbleOwner[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) babbleFlag <= 1'b0;
    else       babbleFlag <= (babbleFlag & ~clrBabble) | setBabble;
  end

  assign irq = babbleFlag & babbleIe;
endmodule

// File: rtl/rx_len_filter.sv
module rx_len_filter
  import rxlf_pkg::*;
#(
  parameter int NUM_BUF  = 3,
  parameter int CNT_W    = 12,
  parameter int CODE_W   = 3,
  parameter int BASE_CAP = 96,
  parameter int MAX_CODE = 4,
  localparam int BUF_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sofIn,
  input  logic [BUF_W-1:0]   bufSel,
  input  logic               byteValid,
  input  logic               eofIn,
  input  logic [CODE_W-1:0]  sizeCode,
  input  logic [CNT_W-1:0]   maxLen,
  input  logic               babbleIe,
  input  logic [NUM_BUF-1:0] clrValid,
  input  logic [NUM_BUF-1:0] clrOverrun,
  input  logic               clrBabble,
  output logic [NUM_BUF-1:0] validFlags,
  output logic [NUM_BUF-1:0] overrunFlags,
  output logic               babbleFlag,
  output logic               irq,
  output logic [NUM_BUF-1:0] bufFree
);
  dpStrobe_t          strobe;
  dpStatus_t          status;
  logic [NUM_BUF-1:0] setValid;
  logic [NUM_BUF-1:0] setOverrun;
  logic               setBabble;

  rxlf_ctrl #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sofIn(sofIn), .bufSel(bufSel),
    .byteValid(byteValid), .eofIn(eofIn), .status(status),
    .strobe(strobe), .setValid(setValid), .setOverrun(setOverrun),
    .setBabble(setBabble)
  );

  rxlf_datapath #(.CNT_W(CNT_W), .CODE_W(CODE_W), .BASE_CAP(BASE_CAP),
                  .MAX_CODE(MAX_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sizeCode(sizeCode),
    .maxLen(maxLen), .status(status)
  );

  rxlf_flags #(.NUM_BUF(NUM_BUF)) u_flags (
    .clk(clk), .rstN(rstN), .setValid(setValid), .setOverrun(setOverrun),
    .setBabble(setBabble), .clrValid(clrValid), .clrOverrun(clrOverrun),
    .clrBabble(clrBabble), .babbleIe(babbleIe), .validFlags(validFlags),
    .overrunFlags(overrunFlags), .babbleFlag(babbleFlag), .irq(irq),
    .bufFree(bufFree)
  );
endmodule

// File: rtl/rxlf_checker.sv
module rxlf_checker #(
  parameter int NUM_BUF = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               eofIn,
  input logic               babbleIe,
  input logic               clrBabble,
  input logic [NUM_BUF-1:0] validFlags,
  input logic [NUM_BUF-1:0] overrunFlags,
  input logic               babbleFlag,
  input logic               irq,
  input logic [NUM_BUF-1:0] bufFree
);
  AST_NEW_FLAG_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rstN)
    ((validFlags & ~$past(validFlags)) != '0) |-> $past(eofIn)); // R4

  AST_DROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    ((validFlags & ~$past(validFlags)) & (overrunFlags & ~$past(overrunFlags))) == '0); // R2

  AST_IRQ_NEEDS_BABBLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (babbleFlag && babbleIe)); // R5

  AST_BABBLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (babbleFlag && !clrBabble) |=> babbleFlag); // R6

  AST_BABBLE_HOLDS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    babbleFlag |-> (bufFree != {NUM_BUF{1'b1}})); // R7
endmodule

bind rx_len_filter rxlf_checker #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk(clk), .rstN(rstN), .eofIn(eofIn), .babbleIe(babbleIe),
  .clrBabble(clrBabble), .validFlags(validFlags), .overrunFlags(overrunFlags),
  .babbleFlag(babbleFlag), .irq(irq), .bufFree(bufFree)
);

// File: tb/rx_len_filter_tb.sv
`timescale 1ns/1ps
module rx_len_filter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sofIn = 1'b0;
  logic [1:0] bufSel = '0;
  logic       byteValid = 1'b0;
  logic       eofIn = 1'b0;
  logic [2:0] sizeCode = '0;
  logic [11:0] maxLen = '0;
  logic       babbleIe = 1'b0;
  logic [2:0] clrValid = '0;
  logic [2:0] clrOverrun = '0;
  logic       clrBabble = 1'b0;
  logic [2:0] validFlags, overrunFlags, bufFree;
  logic       babbleFlag, irq;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  rx_len_filter u_dut (
    .clk(clk), .rstN(rstN), .sofIn(sofIn), .bufSel(bufSel),
    .byteValid(byteValid), .eofIn(eofIn), .sizeCode(sizeCode),
    .maxLen(maxLen), .babbleIe(babbleIe), .clrValid(clrValid),
    .clrOverrun(clrOverrun), .clrBabble(clrBabble), .validFlags(validFlags),
    .overrunFlags(overrunFlags), .babbleFlag(babbleFlag), .irq(irq),
    .bufFree(bufFree)
  );

  typedef struct packed {
    logic [1:0]  bIdx;
    logic [2:0]  code;
    logic [11:0] lim;
    logic [12:0] nBytes;
    logic        expV;
    logic        expO;
    logic        expB;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 3'd0, 12'd200,  13'd96,   1'b1, 1'b0, 1'b0}, // R10 cap boundary
    '{2'd1, 3'd0, 12'd200,  13'd97,   1'b0, 1'b1, 1'b0}, // R1
    '{2'd2, 3'd1, 12'd100,  13'd100,  1'b1, 1'b0, 1'b0}, // R10 max boundary
    '{2'd0, 3'd1, 12'd100,  13'd101,  1'b1, 1'b0, 1'b1}, // R3
    '{2'd1, 3'd4, 12'd2000, 13'd1536, 1'b1, 1'b0, 1'b0}, // R1 largest code
    '{2'd2, 3'd4, 12'd2000, 13'd1537, 1'b0, 1'b1, 1'b0}, // R1
    '{2'd0, 3'd7, 12'd4095, 13'd1537, 1'b0, 1'b1, 1'b0}, // R1 clamp
    '{2'd1, 3'd2, 12'd50,   13'd400,  1'b0, 1'b1, 1'b0}, // R2 both exceeded
    '{2'd2, 3'd3, 12'd700,  13'd768,  1'b1, 1'b0, 1'b1}, // R3
    '{2'd0, 3'd0, 12'd10,   13'd1,    1'b1, 1'b0, 1'b0}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bytes driven at negedge; eof rides on the last byte unless n == 0
  task automatic runFrame(input int b, input int n, input logic [2:0] clrAtEnd);
    @(negedge clk);
    sofIn = 1'b1; bufSel = 2'(b);
    @(negedge clk);
    sofIn = 1'b0;
    for (int i = 0; i < n; i++) begin
      byteValid = 1'b1;
      if (i == n - 1) begin eofIn = 1'b1; clrValid = clrAtEnd; end
      @(negedge clk);
    end
    byteValid = 1'b0; eofIn = 1'b0; clrValid = '0;
  endtask

  task automatic clearAll();
    clrValid = '1; clrOverrun = '1; clrBabble = 1'b1;
    @(negedge clk);
    clrValid = '0; clrOverrun = '0; clrBabble = 1'b0;
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset valid", 32'(validFlags), 0);
    chk("R4 reset overrun", 32'(overrunFlags), 0);
    chk("R7 reset free", 32'(bufFree), 7);
    chk("R5 reset irq", 32'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      sizeCode = VECS[v].code;
      maxLen   = VECS[v].lim;
      runFrame(int'(VECS[v].bIdx), int'(VECS[v].nBytes), 3'b000);
      chk("R1/R3/R4 valid", 32'(validFlags), 32'({2'b0, VECS[v].expV} << VECS[v].bIdx));
      chk("R1/R2 overrun", 32'(overrunFlags), 32'({2'b0, VECS[v].expO} << VECS[v].bIdx));
      chk("R2/R3 babble", 32'(babbleFlag), 32'(VECS[v].expB));
      clearAll();
    end

    // R5 interrupt gating
    sizeCode = 3'd4; maxLen = 12'd20;
    runFrame(1, 30, 3'b000);
    chk("R5 irq disabled", 32'(irq), 0);
    babbleIe = 1'b1; #0.1;
    chk("R5 irq enabled", 32'(irq), 1);
    // R7 release order: valid first, then babble
    chk("R7 held by babble frame", 32'(bufFree), 3'b101);
    clrValid = 3'b010; @(negedge clk); clrValid = '0;
    chk("R7 still held after valid clear", 32'(bufFree), 3'b101);
    clrBabble = 1'b1; @(negedge clk); clrBabble = 1'b0;
    chk("R7 freed after both", 32'(bufFree), 3'b111);
    chk("R5 irq after clear", 32'(irq), 0);
    // R7 release order: babble first, then valid
    runFrame(2, 30, 3'b000);
    clrBabble = 1'b1; @(negedge clk); clrBabble = 1'b0;
    chk("R7 held by valid", 32'(bufFree), 3'b011);
    clrValid = 3'b100; @(negedge clk); clrValid = '0;
    chk("R7 freed", 32'(bufFree), 3'b111);
    babbleIe = 1'b0;

    // R6 clear coinciding with set leaves flag set
    maxLen = 12'd2000;
    runFrame(0, 5, 3'b001);
    chk("R6 set wins over clear", 32'(validFlags), 3'b001);
    clearAll();
    chk("R6 w1c clear", 32'(validFlags), 0);

    // R9 strobes outside a frame
    @(negedge clk);
    byteValid = 1'b1; repeat (5) @(negedge clk);
    eofIn = 1'b1; @(negedge clk);
    byteValid = 1'b0; eofIn = 1'b0; @(negedge clk);
    chk("R9 out-of-frame eof ignored", 32'({validFlags, overrunFlags}), 0);

    // R9 restart mid-frame: 150 bytes then new start, 50 bytes, code 0
    sizeCode = 3'd0;
    @(negedge clk); sofIn = 1'b1; bufSel = 2'd2;
    @(negedge clk); sofIn = 1'b0; byteValid = 1'b1;
    repeat (150) @(negedge clk);
    byteValid = 1'b0;
    runFrame(1, 50, 3'b000);
    chk("R9 restart valid", 32'(validFlags), 3'b010);
    chk("R9 restart overrun", 32'(overrunFlags), 0);
    clearAll();

    // R8 saturating counter
    sizeCode = 3'd7; maxLen = 12'd4095;
    runFrame(0, 4100, 3'b000);
    chk("R8 saturate overrun", 32'(overrunFlags), 3'b001);
    chk("R8 saturate valid", 32'(validFlags), 0);
    clrOverrun = 3'b001; @(negedge clk); clrOverrun = '0;
    chk("R6 overrun w1c", 32'(overrunFlags), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule